// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block serves loads for a direct-mapped data cache whose lines hold eight 64-bit doublewords. A load that misses starts a line fetch over a pipelined memory bus. The fetch begins with the doubleword the load needs and then wraps around the line. One valid flag per doubleword tracks the line being filled. The missing load therefore completes when its own doubleword lands, not when the whole line is in. Later loads to that line complete as soon as their doubleword is present. Loads that hit other lines keep completing while the fill runs.

The tag store is read on the clock edge that accepts a load and is compared in the following cycle. Each entry is padded to a whole number of bytes and written with byte enables. An entry is written one cycle after the lookup that decides the change: it is invalidated on the cycle after the miss decision. It is written valid only after all eight doublewords have arrived. Loads enter through a valid/ready pair and leave on a one-cycle completion strobe with their data. One load is held in the lookup stage at a time.

Top module: `refill_cache`

## Requirements
- R1: While and after reset, `ld_ready` is high, `ld_done` and `mem_req` are low, and every line is treated as not present, so the first load to any line misses.
- R2: A load address is a doubleword address whose low DW_W bits select the doubleword, the next IDX_W bits select the line and the rest form the tag. A miss issues exactly eight reads for the line: first the missing doubleword, then the following doubleword indices in ascending order modulo 8.
- R3: While `mem_req` is high and `mem_stall` is high, the next cycle keeps `mem_req` high with `mem_addr` unchanged. Each cycle without stall advances to the next doubleword.
- R4: The load that caused a fill completes in the cycle after the `mem_ack` that returns its doubleword, even though the rest of the line is still missing.
- R5: A load to the line under fill completes one cycle after acceptance if its doubleword has already arrived. Otherwise it holds `ld_ready` low and completes in the cycle after that doubleword's `mem_ack`.
- R6: A load that hits a fully present line completes in the cycle after acceptance, also while a fill of another line is running. A new load may be accepted in the same cycle, giving one load per cycle.
- R7: A line counts as present in the tag store only after all eight of its doublewords have arrived. From then on, loads to it complete without any memory request.
- R8: A miss to another line while a fill is running, or during the fill's final tag-write cycle, waits with `ld_ready` low and starts its own fill only after that cycle.
- R9: A load whose line index equals that of the line being filled but whose tag differs is a miss, even if the tag store still holds a matching old entry.
- R10: The data returned with `ld_done` equals the memory doubleword at the load's address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | ADDR_W | Doubleword address of the load |
| ld_ready | output | 1 | Load can be taken this cycle |
| ld_done | output | 1 | Held load completes this cycle |
| ld_data | output | 64 | Data of the completing load |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Doubleword address of the read |
| mem_stall | input | 1 | Memory cannot take the request this cycle |
| mem_ack | input | 1 | Read data returned this cycle, in request order |
| mem_rdata | input | 64 | Returned read data |

## Verification
The bench builds the block with ADDR_W=12, IDX_W=2 and DW_W=3: four lines of eight doublewords and a seven-bit tag. The tag byte then carries no padding, while the default build pads an eleven-bit entry to two bytes. The bench draws load tags from only three values. With four lines, this makes same-index conflicts, reloads of just-evicted lines and loads into the line under fill frequent. Every doubleword position occurs as the critical one, so every wrap point of the fill order is reached under varied stall and acknowledge rates.

// File: rtl/rc_pkg.sv
// Shared types and helpers for the refill cache.
// Assumes: nothing beyond IEEE 1800-2017.
package rc_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_RUN   = 2'd1,
        FILL_TAGWR = 2'd2
    } fill_state_e;

    // Round a bit width up to a whole number of bytes.
    function automatic int unsigned pad_to_byte(input int unsigned w);
        return ((w + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/rc_tag_ram.sv
// Tag store: one padded entry per line, read on the clock edge, written
// byte lane by byte lane. Assumes ENTRY_W is a multiple of 8. Reset clears
// all entries so that no line looks present after reset.
module rc_tag_ram #(
    parameter int ENTRY_W = 16,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [ENTRY_W-1:0]   rd_entry,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [ENTRY_W/8-1:0] wr_be,
    input  logic [ENTRY_W-1:0]   wr_entry
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int BYTES = ENTRY_W / 8;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane [DEPTH];
        logic [7:0] q;

        // One byte lane: clear on reset, write when enabled, registered read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane[i] <= '0;
                q <= '0;
            end else begin
                if (wr_en && wr_be[b]) lane[wr_idx] <= wr_entry[8*b +: 8];
                if (rd_en) q <= lane[rd_idx];
            end
        end

        assign rd_entry[8*b +: 8] = q;
    end
endmodule

// File: rtl/rc_data_ram.sv
// Line data store: one 64-bit word per doubleword of every line.
// Read is combinational from the held address; writes land on the edge.
// Assumes contents are only read once written by a fill.
module rc_data_ram #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [63:0]   rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [63:0]   wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [63:0] mem [DEPTH];

    // Store arriving fill data.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rc_refill_ctrl.sv
// Line fill sequencer. On start it records the line and the critical
// doubleword, issues one read per cycle without stall, critical first and
// wrapping, and sets a per-doubleword valid flag on each in-order ack.
// It invalidates the tag entry the cycle after start and writes it valid
// one cycle after the last ack. Assumes acks arrive only for issued reads.
module rc_refill_ctrl
    import rc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int DW_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [IDX_W-1:0]           start_idx,
    input  logic [ADDR_W-IDX_W-DW_W-1:0] start_tag,
    input  logic [DW_W-1:0]            start_dw,
    output logic                       idle,
    output logic                       live,
    output logic [IDX_W-1:0]           line_idx,
    output logic [ADDR_W-IDX_W-DW_W-1:0] line_tag,
    output logic [(1<<DW_W)-1:0]       dw_valid,
    output logic                       mem_req,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic                       mem_stall,
    input  logic                       mem_ack,
    output logic                       fill_we,
    output logic [DW_W-1:0]            fill_dw,
    output logic                       tag_we,
    output logic                       tag_valid
);
    localparam int CNT_W = DW_W + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << DW_W) - 1);

    fill_state_e      state;
    logic [CNT_W-1:0] sent;
    logic [CNT_W-1:0] got;
    logic [DW_W-1:0]  crit;
    logic [DW_W-1:0]  issue_dw;
    logic             inv_pend;

    assign idle     = (state == FILL_IDLE);
    assign issue_dw = crit + sent[DW_W-1:0];
    assign fill_dw  = crit + got[DW_W-1:0];
    assign mem_req  = (state == FILL_RUN) && !sent[DW_W];
    assign mem_addr = {line_tag, line_idx, issue_dw};
    assign fill_we  = (state == FILL_RUN) && mem_ack;
    assign tag_we   = inv_pend || (state == FILL_TAGWR);
    assign tag_valid = (state == FILL_TAGWR);

    // Sequence one line fill and track which doublewords are present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FILL_IDLE;
            sent     <= '0;
            got      <= '0;
            crit     <= '0;
            line_idx <= '0;
            line_tag <= '0;
            live     <= 1'b0;
            dw_valid <= '0;
            inv_pend <= 1'b0;
        end else begin
            inv_pend <= start && idle;
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        state    <= FILL_RUN;
                        line_idx <= start_idx;
                        line_tag <= start_tag;
                        crit     <= start_dw;
                        sent     <= '0;
                        got      <= '0;
                        dw_valid <= '0;
                        live     <= 1'b1;
                    end
                end
                FILL_RUN: begin
                    if (mem_req && !mem_stall) sent <= sent + CNT_W'(1);
                    if (mem_ack) begin
                        dw_valid[fill_dw] <= 1'b1;
                        got <= got + CNT_W'(1);
                        if (got == LAST) state <= FILL_TAGWR;
                    end
                end
                FILL_TAGWR: state <= FILL_IDLE;
                default:    state <= FILL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/refill_cache.sv
// Load side of a direct-mapped cache with critical-word-first refill.
// A load is taken into a lookup stage; the tag store is read on the
// accepting edge and compared in the lookup cycle. The line under fill is
// judged by its per-doubleword flags; other lines by the tag store.
// Assumes the memory returns read data in request order.
module refill_cache
    import rc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int DW_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_ready,
    output logic              ld_done,
    output logic [63:0]       ld_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_stall,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata
);
    localparam int TAG_W   = ADDR_W - IDX_W - DW_W;
    localparam int ENTRY_W = pad_to_byte(TAG_W + 1);
    localparam int LINE_DW = 1 << DW_W;

    logic              b_valid;
    logic [ADDR_W-1:0] b_addr;
    logic [DW_W-1:0]   b_dw;
    logic [IDX_W-1:0]  b_idx;
    logic [TAG_W-1:0]  b_tag;
    logic              accept;

    logic [ENTRY_W-1:0] tq_entry;
    logic               tq_valid;
    logic [TAG_W-1:0]   tq_tag;

    logic               rf_idle;
    logic               rf_live;
    logic [IDX_W-1:0]   rf_idx;
    logic [TAG_W-1:0]   rf_tag;
    logic [LINE_DW-1:0] dw_valid;
    logic               fill_we;
    logic [DW_W-1:0]    fill_dw;
    logic               tag_we;
    logic               tag_wvalid;
    logic [ENTRY_W-1:0] tag_wentry;

    logic b_on_line;
    logic b_same_idx;
    logic b_arr_hit;
    logic b_start;

    assign b_dw  = b_addr[DW_W-1:0];
    assign b_idx = b_addr[DW_W +: IDX_W];
    assign b_tag = b_addr[ADDR_W-1 -: TAG_W];

    assign tq_valid = tq_entry[TAG_W];
    assign tq_tag   = tq_entry[TAG_W-1:0];

    // Hit decision: the line under fill wins over the tag store.
    assign b_on_line  = rf_live && (b_idx == rf_idx) && (b_tag == rf_tag);
    assign b_same_idx = rf_live && (b_idx == rf_idx);
    assign b_arr_hit  = tq_valid && (tq_tag == b_tag) && !b_same_idx;
    assign ld_done    = b_valid && (b_on_line ? dw_valid[b_dw] : b_arr_hit);
    assign b_start    = b_valid && !b_on_line && !b_arr_hit && rf_idle;
    assign ld_ready   = !b_valid || ld_done;
    assign accept     = ld_valid && ld_ready;

    // Lookup stage: hold one load until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_addr  <= '0;
        end else if (ld_ready) begin
            b_valid <= ld_valid;
            if (ld_valid) b_addr <= ld_addr;
        end
    end

    // Assemble the padded tag entry written by the fill sequencer.
    always_comb begin
        tag_wentry = '0;
        tag_wentry[TAG_W:0] = {tag_wvalid, rf_tag};
    end

    rc_tag_ram #(
        .ENTRY_W (ENTRY_W),
        .IDX_W   (IDX_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (accept),
        .rd_idx   (ld_addr[DW_W +: IDX_W]),
        .rd_entry (tq_entry),
        .wr_en    (tag_we),
        .wr_idx   (rf_idx),
        .wr_be    ({(ENTRY_W/8){1'b1}}),
        .wr_entry (tag_wentry)
    );

    rc_data_ram #(
        .AW (IDX_W + DW_W)
    ) u_data (
        .clk     (clk),
        .rd_addr ({b_idx, b_dw}),
        .rd_data (ld_data),
        .wr_en   (fill_we),
        .wr_addr ({rf_idx, fill_dw}),
        .wr_data (mem_rdata)
    );

    rc_refill_ctrl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .DW_W   (DW_W)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (b_start),
        .start_idx (b_idx),
        .start_tag (b_tag),
        .start_dw  (b_dw),
        .idle      (rf_idle),
        .live      (rf_live),
        .line_idx  (rf_idx),
        .line_tag  (rf_tag),
        .dw_valid  (dw_valid),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_stall (mem_stall),
        .mem_ack   (mem_ack),
        .fill_we   (fill_we),
        .fill_dw   (fill_dw),
        .tag_we    (tag_we),
        .tag_valid (tag_wvalid)
    );
endmodule

// File: rtl/refill_cache_chk.sv
// Temporal checks on the refill cache, attached by bind.
// Assumes it sees the top's ports and fill-side signals by name.
module refill_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int DW_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_stall,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              tag_we,
    input logic              tag_wvalid,
    input logic [(1<<DW_W)-1:0] dw_valid,
    input logic              fill_we,
    input logic [DW_W-1:0]   fill_dw,
    input logic              b_valid,
    input logic              b_on_line,
    input logic [DW_W-1:0]   b_dw,
    input logic              ld_done
);
    // R2
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_stall) |=> (!mem_req ||
            ((mem_addr[ADDR_W-1:DW_W] == $past(mem_addr[ADDR_W-1:DW_W])) &&
             (mem_addr[DW_W-1:0] == $past(mem_addr[DW_W-1:0]) + DW_W'(1)))));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_stall) |=> (mem_req && $stable(mem_addr)));

    // R4
    early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && b_valid && b_on_line && (fill_dw == b_dw)) |=> ld_done);

    // R7
    full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we && tag_wvalid) |-> (&dw_valid));
endmodule

bind refill_cache refill_cache_chk #(
    .ADDR_W (ADDR_W),
    .DW_W   (DW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_stall  (mem_stall),
    .mem_addr   (mem_addr),
    .tag_we     (tag_we),
    .tag_wvalid (tag_wvalid),
    .dw_valid   (dw_valid),
    .fill_we    (fill_we),
    .fill_dw    (fill_dw),
    .b_valid    (b_valid),
    .b_on_line  (b_on_line),
    .b_dw       (b_dw),
    .ld_done    (ld_done)
);

// File: tb/refill_cache_bench.sv
// Bench: memory responder plus a behavioural cycle model of the load
// side, compared with the design on every clock.
module refill_cache_bench;
    localparam int AW  = 12;
    localparam int IW  = 2;
    localparam int DWW = 3;
    localparam int NL  = 1 << IW;
    localparam int LD  = 1 << DWW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          ld_valid, ld_ready, ld_done, mem_req, mem_stall, mem_ack;
    logic [AW-1:0] ld_addr, mem_addr;
    logic [63:0]   ld_data, mem_rdata;

    refill_cache #(.ADDR_W(AW), .IDX_W(IW), .DW_W(DWW)) u_refill_cache (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_data(ld_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_stall(mem_stall),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state.
    bit    m_lv [NL];
    int    m_lt [NL];
    int    phase = 0;
    int    li = 0, lt = 0, crit = 0, sent = 0, got = 0;
    bit    live = 0, inv = 0, bv = 0, b_init = 0, tqv = 0, prev_stall = 0;
    bit [LD-1:0] have = '0;
    int    baddr = 0, tqt = 0;
    int    addrq [$];

    function automatic logic [63:0] mem_word(input int a);
        logic [15:0] x;
        x = 16'(a);
        return {x * 16'd7 + 16'd1, ~x, x ^ 16'h3c3c, x};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Compare this cycle's outputs with the model, then advance the model.
    task automatic step_model();
        int bi, bt, bd, ni;
        bit on_line, same_idx, arr, e_done, st, e_req, acc, nv;
        int nt;
        string rq;
        logic [AW-1:0] e_addr;
        bi = (baddr >> DWW) % NL;
        bt = baddr >> (IW + DWW);
        bd = baddr % LD;
        on_line  = live && bi == li && bt == lt;
        same_idx = live && bi == li;
        arr      = tqv && tqt == bt && !same_idx;
        st = 0;
        if (!bv) begin
            e_done = 0; rq = "R6";
        end else if (on_line) begin
            e_done = have[bd]; rq = b_init ? "R4" : "R5";
        end else if (arr) begin
            e_done = 1; rq = (phase != 0) ? "R6" : "R7";
        end else begin
            e_done = 0; rq = same_idx ? "R9" : "R8"; st = (phase == 0);
        end
        check(ld_done == e_done, rq, "ld_done", 64'(ld_done), 64'(e_done));
        check(ld_ready == (!bv || e_done), rq, "ld_ready", 64'(ld_ready), 64'(!bv || e_done));
        if (ld_done && e_done)
            check(ld_data == mem_word(baddr), "R10", "ld_data", ld_data, mem_word(baddr));

        e_req  = (phase == 1) && sent < LD;
        e_addr = AW'((lt << (IW + DWW)) | (li << DWW) | ((crit + sent) % LD));
        check(mem_req == e_req, prev_stall ? "R3" : "R2", "mem_req", 64'(mem_req), 64'(e_req));
        if (e_req && mem_req)
            check(mem_addr == e_addr, prev_stall ? "R3" : "R2", "mem_addr", 64'(mem_addr), 64'(e_addr));
        prev_stall = e_req && mem_stall;

        acc = ld_valid && (!bv || e_done);
        ni  = (int'(ld_addr) >> DWW) % NL;
        nv  = m_lv[ni];
        nt  = m_lt[ni];
        if (inv) begin m_lv[li] = 0; inv = 0; end
        if (phase == 2) begin
            m_lv[li] = 1; m_lt[li] = lt; phase = 0;
        end else if (phase == 1) begin
            if (e_req && !mem_stall) begin addrq.push_back(int'(e_addr)); sent++; end
            if (mem_ack) begin
                void'(addrq.pop_front());
                have[(crit + got) % LD] = 1'b1;
                got++;
                if (got == LD) phase = 2;
            end
        end
        if (st) begin
            phase = 1; li = bi; lt = bt; crit = bd; sent = 0; got = 0;
            have = '0; live = 1; inv = 1; b_init = 1;
        end
        if (acc) begin
            bv = 1; baddr = int'(ld_addr); tqv = nv; tqt = nt; b_init = 0;
        end else if (e_done) begin
            bv = 0;
        end
    endtask

    task automatic run_phase(input int cycles, input int ldp, input int stp, input int ackp);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            ld_valid  = ($urandom_range(99) < ldp);
            ld_addr   = AW'(($urandom_range(2) << (IW + DWW)) |
                            ($urandom_range(NL - 1) << DWW) | $urandom_range(LD - 1));
            mem_stall = ($urandom_range(99) < stp);
            mem_ack   = (addrq.size() > 0) && ($urandom_range(99) < ackp);
            mem_rdata = mem_ack ? mem_word(addrq[0]) : 64'd0;
            #1;
            step_model();
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual still running expected finished");
            finish_run();
        end
    end

    initial begin
        ld_valid = 0; ld_addr = '0; mem_stall = 0; mem_ack = 0; mem_rdata = '0;
        for (int i = 0; i < NL; i++) begin m_lv[i] = 0; m_lt[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        check(ld_ready == 1'b1, "R1", "ld_ready in reset", 64'(ld_ready), 64'd1);
        check(ld_done == 1'b0, "R1", "ld_done in reset", 64'(ld_done), 64'd0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        run_phase(1500, 70, 0, 100);
        run_phase(1500, 60, 30, 60);
        run_phase(1500, 90, 10, 40);
        run_phase(1500, 40, 50, 80);
        finish_run();
    end
endmodule